// File: doc/BRIEF.md
# Six-State Arbitrary-Order Counter

This block is a 3-bit synchronous counter that steps through a fixed cycle of six codes. The order is not binary. Three D flip-flops hold the code. Each flip-flop is fed by a small sum-of-products equation rather than by an adder. Two of the eight codes are not part of the cycle. The next-state equations still send each of them into the cycle on the first enabled clock, so the state diagram has no dead ends.

The counter advances on a rising clock edge while the count enable is high, and holds while it is low. A synchronous active-high reset loads a start code. That code is a parameter: `000` by default, and only changed to start from an unused code when the recovery path is being exercised. A terminal output marks the last code of the cycle, one step before the wrap back to `000`. The code is presented as A, B, C on bits 2, 1, 0 of the state output.

Top module: `six_seq_counter`

## Requirements
- R1: With `rst` low and `en` high at a rising edge, the state (A=bit 2, B=bit 1, C=bit 0) advances one step along the cycle 000, 001, 010, 100, 101, 110 and back to 000.
- R2: With `rst` high at a rising edge, the state becomes `RESET_STATE` (default 000) whatever `en` is.
- R3: With `rst` low and `en` low at a rising edge, the state keeps its value, including when it holds an unused code.
- R4: `term_o` is high exactly while the state is 110, and an enabled step from 110 gives 000.
- R5: An enabled step from the unused code 011 gives 110.
- R6: An enabled step from the unused code 111 gives 010.
- R7: After any enabled step the state is never 011 or 111, so every code reaches the cycle within one clock.
- R8: The next value of each flip-flop follows its own equation: A' = A XOR B, B' = C, C' = NOT B AND NOT C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, loads `RESET_STATE` |
| en | input | 1 | Count enable; the state holds while low |
| state_o | output | 3 | Current code: A on bit 2, B on bit 1, C on bit 0 |
| term_o | output | 1 | High while the state is 110 |

## Verification
The bench builds three copies of the counter. They differ only in `RESET_STATE`, set to 000, 011 and 111. The default copy covers the six-state cycle, the hold and the terminal flag. The two copies that start from an unused code are the only way to reach those codes through the ports, so they are what brings the recovery steps of R5 and R6, and the hold of an unused code under R3, within reach. The same random enable and reset pattern drives all three copies against a lookup-table model.

// File: rtl/six_seq_pkg.sv
`timescale 1ns/1ps
package six_seq_pkg;

  localparam int STATE_W = 3;
  localparam int BIT_A   = 2;
  localparam int BIT_B   = 1;
  localparam int BIT_C   = 0;

  typedef logic [STATE_W-1:0] seq_code_t;

  localparam seq_code_t CODE_FIRST = 3'b000;
  localparam seq_code_t CODE_LAST  = 3'b110;
  localparam seq_code_t CODE_GAP_L = 3'b011;
  localparam seq_code_t CODE_GAP_H = 3'b111;

  // Flip-flop A input: set when exactly one of A, B is high.
  function automatic logic eq_a(input seq_code_t s);
    return (~s[BIT_A] & s[BIT_B]) | (s[BIT_A] & ~s[BIT_B]);
  endfunction

  // Flip-flop B input copies C.
  function automatic logic eq_b(input seq_code_t s);
    return s[BIT_C];
  endfunction

  // Flip-flop C input: set only when both B and C are low.
  function automatic logic eq_c(input seq_code_t s);
    return ~s[BIT_B] & ~s[BIT_C];
  endfunction

  function automatic logic code_is_gap(input seq_code_t s);
    return (s == CODE_GAP_L) || (s == CODE_GAP_H);
  endfunction

  function automatic logic code_is_last(input seq_code_t s);
    return s == CODE_LAST;
  endfunction

endpackage

// File: rtl/six_seq_next.sv
`timescale 1ns/1ps
module six_seq_next
  import six_seq_pkg::*;
(
  input  seq_code_t cur_i,
  output seq_code_t nxt_o
);

  logic bit_a, bit_b, bit_c;

  always_comb begin
    bit_a = eq_a(cur_i);
    bit_b = eq_b(cur_i);
    bit_c = eq_c(cur_i);
  end

  always_comb begin
    nxt_o        = '0;
    nxt_o[BIT_A] = bit_a;
    nxt_o[BIT_B] = bit_b;
    nxt_o[BIT_C] = bit_c;
  end

endmodule

// File: rtl/six_seq_state_reg.sv
`timescale 1ns/1ps
module six_seq_state_reg
  import six_seq_pkg::*;
#(
  parameter seq_code_t RESET_STATE = CODE_FIRST
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  seq_code_t d_i,
  output seq_code_t q_o
);

  for (genvar i = 0; i < STATE_W; i++) begin : g_ff
    logic ff_q;
    always_ff @(posedge clk) begin
      if (rst)
        ff_q <= RESET_STATE[i];
      else if (en)
        ff_q <= d_i[i];
    end
    assign q_o[i] = ff_q;
  end

endmodule

// File: rtl/six_seq_decode.sv
`timescale 1ns/1ps
module six_seq_decode
  import six_seq_pkg::*;
(
  input  seq_code_t state_i,
  output logic      last_o,
  output logic      gap_o
);

  always_comb begin
    last_o = code_is_last(state_i);
    gap_o  = code_is_gap(state_i);
  end

endmodule

// File: rtl/six_seq_counter.sv
`timescale 1ns/1ps
module six_seq_counter
  import six_seq_pkg::*;
#(
  parameter logic [2:0] RESET_STATE = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [2:0] state_o,
  output logic       term_o
);

  seq_code_t state_q;
  seq_code_t nxt_state;
  logic      last_hit;
  logic      gap_hit;

  six_seq_next u_next (
    .cur_i (state_q),
    .nxt_o (nxt_state)
  );

  six_seq_state_reg #(
    .RESET_STATE (RESET_STATE)
  ) u_reg (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d_i (nxt_state),
    .q_o (state_q)
  );

  six_seq_decode u_dec (
    .state_i (state_q),
    .last_o  (last_hit),
    .gap_o   (gap_hit)
  );

  assign state_o = state_q;
  assign term_o  = last_hit;

endmodule

// File: rtl/six_seq_chk.sv
`timescale 1ns/1ps
module six_seq_chk #(
  parameter logic [2:0] RESET_STATE = 3'b000
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [2:0] state_q,
  input logic [2:0] nxt_state,
  input logic       term_o,
  input logic       gap_hit
);

  AST_RESET_LOAD: assert property (@(posedge clk) rst |=> state_q == RESET_STATE); // R2

  AST_STEP_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && state_q == 3'b000) |=> state_q == 3'b001); // R1

  AST_STEP_FROM_FIVE: assert property (@(posedge clk) disable iff (rst)
    (en && state_q == 3'b101) |=> state_q == 3'b110); // R1

  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state_q)); // R3

  AST_TERM_MATCH: assert property (@(posedge clk) disable iff (rst)
    term_o |-> state_q == 3'b110); // R4

  AST_TERM_WRAP: assert property (@(posedge clk) disable iff (rst)
    (term_o && en) |=> state_q == 3'b000); // R4

  AST_GAP_LOW_EXIT: assert property (@(posedge clk) disable iff (rst)
    (en && state_q == 3'b011) |=> state_q == 3'b110); // R5

  AST_GAP_HIGH_EXIT: assert property (@(posedge clk) disable iff (rst)
    (en && state_q == 3'b111) |=> state_q == 3'b010); // R6

  AST_ENABLED_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    en |=> !gap_hit); // R7

  AST_NEXT_B_COPY: assert property (@(posedge clk) disable iff (rst)
    nxt_state[1] == state_q[0]); // R8

endmodule

bind six_seq_counter six_seq_chk #(
  .RESET_STATE (RESET_STATE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .state_q   (state_q),
  .nxt_state (nxt_state),
  .term_o    (term_o),
  .gap_hit   (gap_hit)
);

// File: tb/tb_six_seq_counter.sv
`timescale 1ns/1ps
module tb_six_seq_counter;

  localparam int NUM_DUT = 3;
  localparam int RAND_CYCLES = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;

  logic [2:0] st [NUM_DUT];
  logic       tm [NUM_DUT];
  logic [2:0] rst_code [NUM_DUT];
  logic [2:0] exp_st [NUM_DUT];
  string      cause;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  six_seq_counter #(.RESET_STATE(3'b000)) dut (
    .clk(clk), .rst(rst), .en(en), .state_o(st[0]), .term_o(tm[0]));
  six_seq_counter #(.RESET_STATE(3'b011)) dut_gap_lo (
    .clk(clk), .rst(rst), .en(en), .state_o(st[1]), .term_o(tm[1]));
  six_seq_counter #(.RESET_STATE(3'b111)) dut_gap_hi (
    .clk(clk), .rst(rst), .en(en), .state_o(st[2]), .term_o(tm[2]));

  // Successor of each code, written as a plain table of the cycle.
  function automatic logic [2:0] ref_succ(input logic [2:0] s);
    case (s)
      3'd0: return 3'd1;
      3'd1: return 3'd2;
      3'd2: return 3'd4;
      3'd4: return 3'd5;
      3'd5: return 3'd6;
      3'd6: return 3'd0;
      3'd3: return 3'd6;
      default: return 3'd2;
    endcase
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NUM_DUT; i++) begin
      check(tag, st[i], exp_st[i]);
      check("R4", {2'b00, tm[i]}, {2'b00, exp_st[i] == 3'b110});
      if (cause != "hold" && cause != "reset")
        check("R7", {2'b00, (st[i] == 3'b011) || (st[i] == 3'b111)}, 3'b000);
    end
  endtask

  // At a falling edge: set inputs for the next rising edge, advance the model.
  task automatic drive(input logic r, input logic e);
    @(negedge clk);
    rst = r;
    en  = e;
    for (int i = 0; i < NUM_DUT; i++) begin
      if (r)      exp_st[i] = rst_code[i];
      else if (e) exp_st[i] = ref_succ(exp_st[i]);
    end
    cause = r ? "reset" : (e ? "step" : "hold");
    @(posedge clk);
    #2;
  endtask

  initial begin
    rst_code[0] = 3'b000;
    rst_code[1] = 3'b011;
    rst_code[2] = 3'b111;
    void'($urandom(32'd24681));
    cause = "reset";

    drive(1'b1, 1'b1);
    check_all("R2");

    // Hold of the starting codes, including the unused ones (R3).
    drive(1'b0, 1'b0);
    check_all("R3");
    drive(1'b0, 1'b0);
    check("R3", st[1], 3'b011);
    check("R3", st[2], 3'b111);

    // First enabled step: unused codes rejoin the cycle (R5, R6).
    drive(1'b0, 1'b1);
    check("R5", st[1], 3'b110);
    check("R6", st[2], 3'b010);
    check("R1", st[0], 3'b001);
    check("R4", {2'b00, tm[1]}, 3'b001);

    // Wrap from 110 on the copy that landed there (R4), and R8 bit B = old C.
    drive(1'b0, 1'b1);
    check("R4", st[1], 3'b000);
    check("R8", st[0], 3'b010);
    check("R8", st[2], 3'b100);

    // Walk the default copy round the full cycle twice (R1).
    for (int k = 0; k < 12; k++) begin
      drive(1'b0, 1'b1);
      check_all("R1");
    end

    // Reset with enable low still loads the start code (R2).
    drive(1'b1, 1'b0);
    check_all("R2");

    // Random enable and occasional reset.
    for (int k = 0; k < RAND_CYCLES; k++) begin
      drive(($urandom % 40) == 0, ($urandom % 4) != 0);
      if (cause == "reset")     check_all("R2");
      else if (cause == "hold") check_all("R3");
      else                      check_all("R1");
    end

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

endmodule